// File: doc/BRIEF.md
# Bus Slave Front-End Adapter

This block sits between an AHB-Lite bus and an internal function unit. It watches the bus for a single transfer aimed at its region of the address map. When it finds one, it registers the address-phase fields: the full address, the transfer size, the transfer type and the direction. In the following data phase it also registers the write data. It presents all of these to the internal side on forwarding outputs, so the internal unit never samples the bus directly.

The internal unit answers through three inputs: completion, error response and read data. The adapter stretches the bus data phase with wait states until the internal unit reports completion. At that point it relays the response and the read data onto the bus. A pending flag on the internal side is high while transfer data is still on its way, and its falling edge tells the internal unit that everything has arrived.

The sequencing uses three states. IDLE waits for an address phase. WRITING is the first data-phase cycle, in which the write data is taken. BUSY waits for internal completion. The region is chosen by the top address nibble, which a parameter sets.

Top module: `ahbfe_slave`

## Requirements
- R1: While reset is asserted and right after it, the bus ready output is 1, the response is 0 (OKAY), the read data is 0, the pending flag is 0 and every forwarding output is 0.
- R2: A transfer is taken only on a clock edge where all four of these hold: the select input is 1, the bus-ready input is 1, address bits [31:28] equal the `REGION` parameter (default 4'hA), and the transfer type is NONSEQ (2'b10) or SEQ (2'b11). If any of them fails, the forwarding outputs keep their values and the block stays idle.
- R3: On the edge that takes a transfer, the address, the size, the transfer type and the direction (1 = write) are registered onto the forwarding outputs. They hold until the next transfer is taken.
- R4: For a write, the write data present in the cycle after acceptance is registered onto the forwarding write-data output. A read leaves that output unchanged.
- R5: The pending flag rises on the accepting edge and falls on the next edge, once the data phase has delivered its data. It is never high for two cycles in a row.
- R6: In idle, including when the transfer type is IDLE (2'b00) or BUSY (2'b01), the bus ready output is 1 and the response is OKAY: no wait states and no error.
- R7: The bus ready output is 0 in the first data-phase cycle. After that it follows the internal completion input, and the transfer ends on the edge where completion is 1.
- R8: In the waiting state, the bus response and the bus read data are driven from the internal response and read-data inputs. Outside that state the read data is 0.
- R9: If a new qualifying address phase is present in the cycle where completion is 1, that transfer is taken at once, with no idle cycle between the two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Reset, active low |
| bus_addr | input | 32 | Bus address |
| bus_sel | input | 1 | Slave select |
| bus_ready_in | input | 1 | Bus-wide ready (previous transfer finished) |
| bus_size | input | 3 | Transfer size |
| bus_trans | input | 2 | Transfer type |
| bus_write | input | 1 | Direction, 1 = write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data to the bus |
| bus_ready_out | output | 1 | Ready driven onto the bus |
| bus_resp | output | 1 | Response, 1 = error |
| core_done | input | 1 | Internal completion |
| core_err | input | 1 | Internal error response |
| core_rdata | input | 32 | Internal read data |
| fwd_addr | output | 32 | Registered address |
| fwd_wdata | output | 32 | Registered write data |
| fwd_size | output | 3 | Registered size |
| fwd_trans | output | 2 | Registered transfer type |
| fwd_write | output | 1 | Registered direction |
| fwd_pending | output | 1 | High while transfer data is still arriving |

## Verification
The hardest case to reach is the back-to-back hand-over. A new address phase has to meet the very cycle in which the internal unit signals completion. If the two are a cycle apart, the test falls back to an idle gap and proves nothing. The bench's directed task holds completion low for a chosen number of wait cycles. It then raises completion and drives the next NONSEQ address in the same negative-edge slot. Finally it checks that the pending flag and the new address appear right after that edge, with no idle cycle in between.

// File: rtl/ahbfe_pkg.sv
package ahbfe_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WRITING = 2'd1,
    ST_BUSY    = 2'd2
  } fe_state_t;

  localparam logic [1:0] TR_IDLE   = 2'b00;
  localparam logic [1:0] TR_BUSY   = 2'b01;
  localparam logic [1:0] TR_NONSEQ = 2'b10;
  localparam logic [1:0] TR_SEQ    = 2'b11;

  // A transfer type that carries data (NONSEQ or SEQ).
  function automatic logic trans_carries_data(input logic [1:0] tr);
    return (tr == TR_NONSEQ) || (tr == TR_SEQ);
  endfunction

  // Region hit on the most significant address bits.
  function automatic logic region_hit(input logic [3:0] top_bits,
                                      input logic [3:0] region);
    return top_bits == region;
  endfunction

endpackage

// File: rtl/ahbfe_decode.sv
module ahbfe_decode
  import ahbfe_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [3:0] REGION = 4'hA
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_sel,
  input  logic              bus_ready_in,
  input  logic [1:0]        bus_trans,
  output logic              take
);
  localparam int TOP_LSB = ADDR_W - 4;

  logic hit;
  logic active;

  always_comb begin
    hit    = region_hit(bus_addr[ADDR_W-1:TOP_LSB], REGION);
    active = trans_carries_data(bus_trans);
    take   = bus_sel && bus_ready_in && hit && active;
  end
endmodule

// File: rtl/ahbfe_fsm.sv
module ahbfe_fsm
  import ahbfe_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              core_done,
  input  logic              core_err,
  input  logic [DATA_W-1:0] core_rdata,
  output fe_state_t         state,
  output logic              data_phase,
  output logic              busy_finish,
  output logic              pending,
  output logic              bus_ready_out,
  output logic              bus_resp,
  output logic [DATA_W-1:0] bus_rdata
);
  fe_state_t nxt;

  always_comb begin
    data_phase  = (state == ST_WRITING);
    busy_finish = (state == ST_BUSY) && core_done;
    nxt = state;
    unique case (state)
      ST_IDLE:    if (take) nxt = ST_WRITING;
      ST_WRITING: nxt = ST_BUSY;
      ST_BUSY:    if (core_done) nxt = take ? ST_WRITING : ST_IDLE;
      default:    nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      pending <= 1'b0;
    end else begin
      state   <= nxt;
      pending <= (nxt == ST_WRITING);
    end
  end

  always_comb begin
    bus_ready_out = 1'b1;
    bus_resp      = 1'b0;
    bus_rdata     = '0;
    unique case (state)
      ST_WRITING: bus_ready_out = 1'b0;
      ST_BUSY: begin
        bus_ready_out = core_done;
        bus_resp      = core_err;
        bus_rdata     = core_rdata;
      end
      default: ;
    endcase
  end

  a_r5_pending_single: assert property (@(posedge clk) disable iff (!rst_n)
    pending |=> !pending);
  a_r2_take_enters_data: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (state == ST_IDLE)) |=> (pending && (state == ST_WRITING)));
  a_r7_first_data_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WRITING) |-> !bus_ready_out);
  a_r6_idle_okay: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> (bus_ready_out && !bus_resp));
  a_r9_handover: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_finish && take) |=> pending);
  a_r7_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_BUSY) && !core_done) |=> (state == ST_BUSY));
endmodule

// File: rtl/ahbfe_capture.sv
module ahbfe_capture #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              data_phase,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [2:0]        bus_size,
  input  logic [1:0]        bus_trans,
  input  logic              bus_write,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [DATA_W-1:0] fwd_wdata,
  output logic [2:0]        fwd_size,
  output logic [1:0]        fwd_trans,
  output logic              fwd_write
);
  logic wdata_load;
  assign wdata_load = data_phase && fwd_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_addr  <= '0;
      fwd_size  <= '0;
      fwd_trans <= '0;
      fwd_write <= 1'b0;
    end else if (take) begin
      fwd_addr  <= bus_addr;
      fwd_size  <= bus_size;
      fwd_trans <= bus_trans;
      fwd_write <= bus_write;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          fwd_wdata <= '0;
    else if (wdata_load) fwd_wdata <= bus_wdata;
  end

  a_r3_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> ($stable(fwd_addr) && $stable(fwd_size) && $stable(fwd_trans)
               && $stable(fwd_write)));
  a_r4_read_keeps_wdata: assert property (@(posedge clk) disable iff (!rst_n)
    (data_phase && !fwd_write) |=> $stable(fwd_wdata));
  a_r4_wdata_only_in_data: assert property (@(posedge clk) disable iff (!rst_n)
    !data_phase |=> $stable(fwd_wdata));
endmodule

// File: rtl/ahbfe_slave.sv
module ahbfe_slave
  import ahbfe_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter logic [3:0] REGION = 4'hA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_sel,
  input  logic              bus_ready_in,
  input  logic [2:0]        bus_size,
  input  logic [1:0]        bus_trans,
  input  logic              bus_write,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ready_out,
  output logic              bus_resp,
  input  logic              core_done,
  input  logic              core_err,
  input  logic [DATA_W-1:0] core_rdata,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [DATA_W-1:0] fwd_wdata,
  output logic [2:0]        fwd_size,
  output logic [1:0]        fwd_trans,
  output logic              fwd_write,
  output logic              fwd_pending
);
  logic      take;
  logic      take_ok;
  logic      data_phase;
  logic      busy_finish;
  fe_state_t state;

  ahbfe_decode #(.ADDR_W(ADDR_W), .REGION(REGION)) u_decode (
    .bus_addr     (bus_addr),
    .bus_sel      (bus_sel),
    .bus_ready_in (bus_ready_in),
    .bus_trans    (bus_trans),
    .take         (take)
  );

  // A new address phase is only taken when the FSM can start a data phase.
  assign take_ok = take && ((state == ST_IDLE) || busy_finish);

  ahbfe_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .take          (take_ok),
    .core_done     (core_done),
    .core_err      (core_err),
    .core_rdata    (core_rdata),
    .state         (state),
    .data_phase    (data_phase),
    .busy_finish   (busy_finish),
    .pending       (fwd_pending),
    .bus_ready_out (bus_ready_out),
    .bus_resp      (bus_resp),
    .bus_rdata     (bus_rdata)
  );

  ahbfe_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take_ok),
    .data_phase (data_phase),
    .bus_addr   (bus_addr),
    .bus_size   (bus_size),
    .bus_trans  (bus_trans),
    .bus_write  (bus_write),
    .bus_wdata  (bus_wdata),
    .fwd_addr   (fwd_addr),
    .fwd_wdata  (fwd_wdata),
    .fwd_size   (fwd_size),
    .fwd_trans  (fwd_trans),
    .fwd_write  (fwd_write)
  );

  a_r8_resp_relay: assert property (@(posedge clk) disable iff (!rst_n)
    busy_finish |-> ((bus_resp == core_err) && (bus_rdata == core_rdata)));
  a_r2_no_take_no_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && (state == ST_IDLE)) |=> !fwd_pending);
endmodule

// File: tb/ahbfe_slave_tb.sv
module ahbfe_slave_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] bus_addr = '0;
  logic        bus_sel = 1'b0;
  logic        bus_ready_in = 1'b1;
  logic [2:0]  bus_size = '0;
  logic [1:0]  bus_trans = '0;
  logic        bus_write = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ready_out;
  logic        bus_resp;
  logic        core_done = 1'b0;
  logic        core_err = 1'b0;
  logic [31:0] core_rdata = '0;
  logic [31:0] fwd_addr;
  logic [31:0] fwd_wdata;
  logic [2:0]  fwd_size;
  logic [1:0]  fwd_trans;
  logic        fwd_write;
  logic        fwd_pending;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  ahbfe_slave u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_sel(bus_sel),
    .bus_ready_in(bus_ready_in), .bus_size(bus_size), .bus_trans(bus_trans),
    .bus_write(bus_write), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready_out(bus_ready_out), .bus_resp(bus_resp), .core_done(core_done),
    .core_err(core_err), .core_rdata(core_rdata), .fwd_addr(fwd_addr),
    .fwd_wdata(fwd_wdata), .fwd_size(fwd_size), .fwd_trans(fwd_trans),
    .fwd_write(fwd_write), .fwd_pending(fwd_pending)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // Advance to the next falling edge and let combinational outputs settle.
  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic bus_quiet();
    bus_sel = 1'b0; bus_trans = 2'b00; bus_write = 1'b0; bus_ready_in = 1'b1;
  endtask

  task automatic drive_addr(input logic [31:0] a, input logic wr,
                            input logic [2:0] sz, input logic [1:0] tr);
    bus_addr = a; bus_write = wr; bus_size = sz; bus_trans = tr;
    bus_sel = 1'b1; bus_ready_in = 1'b1;
  endtask

  task automatic t_reset();
    #1;
    check("R1", "ready during reset", {31'd0, bus_ready_out}, 32'd1);
    check("R1", "resp during reset", {31'd0, bus_resp}, 32'd0);
    check("R1", "pending during reset", {31'd0, fwd_pending}, 32'd0);
    check("R1", "fwd_addr during reset", fwd_addr, 32'd0);
    check("R1", "fwd_wdata during reset", fwd_wdata, 32'd0);
    check("R1", "rdata during reset", bus_rdata, 32'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    tick();
    check("R1", "ready after reset", {31'd0, bus_ready_out}, 32'd1);
    check("R1", "fwd_write after reset", {31'd0, fwd_write}, 32'd0);
  endtask

  // Full write with a given number of wait cycles in the waiting state.
  task automatic t_write(input logic [31:0] a, input logic [31:0] d, input int waits);
    drive_addr(a, 1'b1, 3'd2, 2'b10);
    tick();                       // accepting edge passed: data phase 1
    bus_quiet();
    bus_wdata = d;
    check("R3", "write addr forwarded", fwd_addr, a);
    check("R3", "size forwarded", {29'd0, fwd_size}, 32'd2);
    check("R3", "trans forwarded", {30'd0, fwd_trans}, 32'd2);
    check("R3", "dir forwarded", {31'd0, fwd_write}, 32'd1);
    check("R5", "pending high in data phase", {31'd0, fwd_pending}, 32'd1);
    check("R7", "ready low first data cycle", {31'd0, bus_ready_out}, 32'd0);
    tick();                       // data captured, waiting state
    bus_wdata = ~d;
    check("R4", "write data captured", fwd_wdata, d);
    check("R5", "pending fell", {31'd0, fwd_pending}, 32'd0);
    for (int i = 0; i < waits; i++) begin
      check("R7", "ready low while core busy", {31'd0, bus_ready_out}, 32'd0);
      tick();
    end
    core_done = 1'b1; core_err = 1'b0;
    #1;
    check("R7", "ready follows completion", {31'd0, bus_ready_out}, 32'd1);
    tick();
    core_done = 1'b0;
    check("R6", "idle ready after write", {31'd0, bus_ready_out}, 32'd1);
    check("R4", "wdata stable after end", fwd_wdata, d);
  endtask

  task automatic t_read(input logic [31:0] a, input logic [31:0] rd, input logic err);
    logic [31:0] prev_wd;
    prev_wd = fwd_wdata;
    drive_addr(a, 1'b0, 3'd0, 2'b11);
    tick();
    bus_quiet();
    bus_wdata = 32'hDEAD_0000;
    check("R3", "read dir forwarded", {31'd0, fwd_write}, 32'd0);
    check("R3", "SEQ trans forwarded", {30'd0, fwd_trans}, 32'd3);
    tick();
    check("R4", "read leaves wdata", fwd_wdata, prev_wd);
    core_done = 1'b1; core_err = err; core_rdata = rd;
    #1;
    check("R8", "read data relayed", bus_rdata, rd);
    check("R8", "response relayed", {31'd0, bus_resp}, {31'd0, err});
    tick();
    core_done = 1'b0; core_err = 1'b0;
    check("R8", "rdata zero in idle", bus_rdata, 32'd0);
    check("R6", "resp okay in idle", {31'd0, bus_resp}, 32'd0);
  endtask

  task automatic t_rejects();
    logic [31:0] prev_a;
    prev_a = fwd_addr;
    drive_addr(32'hA000_0100, 1'b1, 3'd1, 2'b00);  // IDLE type
    tick();
    check("R6", "IDLE type ready", {31'd0, bus_ready_out}, 32'd1);
    check("R6", "IDLE type not pending", {31'd0, fwd_pending}, 32'd0);
    drive_addr(32'hA000_0104, 1'b1, 3'd1, 2'b01);  // BUSY type
    tick();
    check("R6", "BUSY type okay", {31'd0, bus_resp}, 32'd0);
    check("R6", "BUSY type not pending", {31'd0, fwd_pending}, 32'd0);
    drive_addr(32'hB000_0100, 1'b1, 3'd1, 2'b10);  // wrong region
    tick();
    check("R2", "region miss not taken", {31'd0, fwd_pending}, 32'd0);
    drive_addr(32'hA000_0108, 1'b1, 3'd1, 2'b10);
    bus_sel = 1'b0;
    tick();
    check("R2", "no select not taken", {31'd0, fwd_pending}, 32'd0);
    drive_addr(32'hA000_010C, 1'b1, 3'd1, 2'b10);
    bus_ready_in = 1'b0;
    tick();
    check("R2", "bus not ready not taken", {31'd0, fwd_pending}, 32'd0);
    bus_quiet();
    check("R2", "fwd_addr unchanged", fwd_addr, prev_a);
  endtask

  task automatic t_handover();
    drive_addr(32'hA000_2000, 1'b1, 3'd2, 2'b10);
    tick();
    bus_quiet();
    bus_wdata = 32'h1111_2222;
    tick();
    tick();                       // one wait cycle
    core_done = 1'b1;
    drive_addr(32'hA000_3000, 1'b0, 3'd2, 2'b10);
    tick();
    core_done = 1'b0;
    bus_quiet();
    check("R9", "next transfer pending at once", {31'd0, fwd_pending}, 32'd1);
    check("R9", "next address forwarded", fwd_addr, 32'hA000_3000);
    check("R9", "ready low in new data phase", {31'd0, bus_ready_out}, 32'd0);
    tick();
    core_done = 1'b1;
    tick();
    core_done = 1'b0;
    check("R9", "returned to idle", {31'd0, bus_ready_out}, 32'd1);
  endtask

  initial begin
    t_reset();
    t_write(32'hA000_0010, 32'hCAFE_F00D, 0);
    t_write(32'hA123_4568, 32'h0BAD_BEEF, 3);
    t_read(32'hAFFF_FFFC, 32'h5A5A_A5A5, 1'b0);
    t_read(32'hA000_0040, 32'h0000_0001, 1'b1);
    t_rejects();
    t_handover();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule